// File: doc/BRIEF.md
# Cartridge Bank Controller with Clock Snapshot

This block sits between an 8-bit CPU with a 16-bit address bus and a cartridge ROM and RAM. It turns CPU stores into the lower half of the address space into control commands, since those addresses hold read-only memory. From its state it forms a banked ROM address, a banked external-RAM address, a RAM chip select and a RAM write enable. It also keeps five clock registers that share the external-RAM window with the RAM banks.

A free-running clock counter (seconds, minutes, hours and a 9-bit day count) is an input. Software captures it into the clock registers with a write of 0 then 1 to the latch control region. While a clock register is selected, reads and writes of the window reach that register and not RAM. The block returns the data for the window only. Outside the window its read output is 0xFF, and the ROM data path is outside this block.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A CPU write with address bit 15 clear never asserts the RAM write enable. Address bits [14:13] pick the control region: 0 RAM gate, 1 ROM bank, 2 window select, 3 clock latch.
- R2: A write of 0x0A to the RAM gate region enables external RAM and 0x00 disables it. Any other value leaves the gate unchanged. The change shows from the cycle after the write.
- R3: The ROM bank region takes the low 7 bits of the written value. A result of 0 selects bank 1.
- R4: A write of 0x00–0x03 to the window select region picks that RAM bank and deselects the clock. A write of 0x08–0x0C selects clock register (value − 8). Other values change nothing.
- R5: A write of 0x01 to the latch region captures the counter only when the latch flag is clear, and it sets the flag. A write of 0x00 clears the flag when it is set.
- R6: A capture loads register 0 with seconds, 1 with minutes, 2 with hours and 3 with day bits [7:0]. Register 4 keeps bits [7:4], gets day bit 8 in bit 0 and gets zero in bits [3:1].
- R7: A read of 0xA000–0xBFFF returns the selected clock register when a clock register is selected. Otherwise it returns RAM data when RAM is enabled. Otherwise it returns 0xFF.
- R8: Addresses 0x0000–0x3FFF map to ROM bank 0. Addresses 0x4000–0x7FFF map to the selected bank, with rom_addr = {bank, addr[13:0]}.
- R9: After reset the ROM bank is 1, the RAM bank is 0, RAM is disabled, no clock register is selected, the latch flag is clear and all clock registers are zero.
- R10: The ROM bank driven out is the selected bank masked with ROM_BANKS − 1.
- R11: A CPU write to the window stores into the selected clock register without a RAM write. With no clock register selected and RAM enabled, the write asserts ram_we.
- R12: ram_addr is {RAM bank, addr[12:0]}. ram_cs is high for window addresses when RAM is enabled and no clock register is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one per clock |
| ram_rdata | input | 8 | Data from external RAM |
| cnt_sec | input | 8 | Running seconds |
| cnt_min | input | 8 | Running minutes |
| cnt_hour | input | 8 | Running hours |
| cnt_day | input | 9 | Running day count |
| rom_addr | output | log2(ROM_BANKS)+14 | Banked ROM address |
| ram_addr | output | log2(RAM_BANKS)+13 | Banked external-RAM address |
| ram_cs | output | 1 | External RAM select |
| ram_we | output | 1 | External RAM write enable |
| win_rdata | output | 8 | Read data for the external window |

## Verification
The bench writes bank 0 and expects bank 1. If the remap were missing, upper ROM reads would alias bank 0. It writes 0x1 twice and then 0 then 1, so a latch without its flag would overwrite the first snapshot on the repeated 0x1. It puts a value in the fifth clock register and then latches. A design that cleared the whole register, or put the day bit in the wrong place, would read back something other than 0xF1. It also writes out-of-range values to the gate and select regions, writes bank values above the configured ROM size, and checks that a store to the clock window does not raise ram_we.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    localparam int unsigned CBC_ROM_BANK_W = 7;
    localparam int unsigned CBC_RAM_SEL_W  = 2;
    localparam int unsigned CBC_CLK_REGS   = 5;
    localparam int unsigned CBC_CLK_IDX_W  = 3;
    localparam logic [7:0]  CBC_GATE_ON    = 8'h0A;
    localparam logic [7:0]  CBC_GATE_OFF   = 8'h00;
    localparam logic [7:0]  CBC_CLK_FIRST  = 8'h08;
    localparam logic [7:0]  CBC_CLK_LAST   = 8'h0C;

    typedef enum logic [1:0] {
        RGN_GATE    = 2'd0,
        RGN_ROMBANK = 2'd1,
        RGN_WINSEL  = 2'd2,
        RGN_LATCH   = 2'd3
    } cbc_region_e;

    typedef struct packed {
        logic                      ram_on;
        logic [CBC_ROM_BANK_W-1:0] rom_bank;
        logic [CBC_RAM_SEL_W-1:0]  ram_bank;
        logic                      clk_sel;
        logic [CBC_CLK_IDX_W-1:0]  clk_idx;
        logic                      latched;
    } cbc_ctrl_t;

endpackage

// File: rtl/cbc_ctrl_regs.sv
module cbc_ctrl_regs
    import cbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_wr,
    output cbc_ctrl_t   ctrl,
    output logic        snap_pulse
);

    cbc_ctrl_t   st_d, st_q;
    logic        snap_d;
    logic        ctl_wr;
    cbc_region_e rgn;

    assign ctl_wr = cpu_wr && !cpu_addr[15];
    assign rgn    = cbc_region_e'(cpu_addr[14:13]);

    always_comb begin
        st_d   = st_q;
        snap_d = 1'b0;
        if (ctl_wr) begin
            unique case (rgn)
                RGN_GATE: begin
                    if (cpu_wdata == CBC_GATE_ON) begin
                        st_d.ram_on = 1'b1;
                    end else if (cpu_wdata == CBC_GATE_OFF) begin
                        st_d.ram_on = 1'b0;
                    end
                end
                RGN_ROMBANK: begin
                    st_d.rom_bank = cpu_wdata[CBC_ROM_BANK_W-1:0];
                    if (cpu_wdata[CBC_ROM_BANK_W-1:0] == '0) begin
                        st_d.rom_bank = CBC_ROM_BANK_W'(1);
                    end
                end
                RGN_WINSEL: begin
                    if (cpu_wdata < 8'd4) begin
                        st_d.ram_bank = cpu_wdata[CBC_RAM_SEL_W-1:0];
                        st_d.clk_sel  = 1'b0;
                    end else if (cpu_wdata >= CBC_CLK_FIRST && cpu_wdata <= CBC_CLK_LAST) begin
                        st_d.clk_idx = CBC_CLK_IDX_W'(cpu_wdata - CBC_CLK_FIRST);
                        st_d.clk_sel = 1'b1;
                    end
                end
                RGN_LATCH: begin
                    if (cpu_wdata == 8'h01 && !st_q.latched) begin
                        st_d.latched = 1'b1;
                        snap_d       = 1'b1;
                    end else if (cpu_wdata == 8'h00 && st_q.latched) begin
                        st_d.latched = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ram_on   <= 1'b0;
            st_q.rom_bank <= CBC_ROM_BANK_W'(1);
            st_q.ram_bank <= '0;
            st_q.clk_sel  <= 1'b0;
            st_q.clk_idx  <= '0;
            st_q.latched  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl       = st_q;
    assign snap_pulse = snap_d;

    AST_GATE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && cpu_addr[14:13] == 2'd0 && cpu_wdata == 8'h0A) |=> st_q.ram_on) // R2
        else $error("gate did not open");
    AST_GATE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && cpu_addr[14:13] == 2'd0 && cpu_wdata == 8'h00) |=> !st_q.ram_on) // R2
        else $error("gate did not close");
    AST_ZERO_BANK_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && cpu_addr[14:13] == 2'd1 && cpu_wdata[6:0] == 7'd0) |=> (st_q.rom_bank == 7'd1)) // R3
        else $error("bank zero not remapped");
    AST_SNAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        snap_pulse |=> (st_q.latched && !snap_pulse)) // R5
        else $error("latch flag not set after capture");

endmodule

// File: rtl/cbc_clock_file.sv
module cbc_clock_file
    import cbc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     snap,
    input  logic                     cpu_we,
    input  logic [CBC_CLK_IDX_W-1:0] idx,
    input  logic [7:0]               cpu_wdata,
    input  logic [7:0]               cnt_sec,
    input  logic [7:0]               cnt_min,
    input  logic [7:0]               cnt_hour,
    input  logic [8:0]               cnt_day,
    output logic [7:0]               rdata
);

    logic [7:0] regs_d [CBC_CLK_REGS];
    logic [7:0] regs_q [CBC_CLK_REGS];

    always_comb begin
        for (int i = 0; i < CBC_CLK_REGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (snap) begin
            regs_d[0] = cnt_sec;
            regs_d[1] = cnt_min;
            regs_d[2] = cnt_hour;
            regs_d[3] = cnt_day[7:0];
            regs_d[4] = {regs_q[4][7:4], 3'b000, cnt_day[8]};
        end else if (cpu_we && idx < CBC_CLK_IDX_W'(CBC_CLK_REGS)) begin
            regs_d[idx] = cpu_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CBC_CLK_REGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < CBC_CLK_REGS; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign rdata = (idx < CBC_CLK_IDX_W'(CBC_CLK_REGS)) ? regs_q[idx] : 8'hFF;

    AST_SNAP_SECONDS: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (regs_q[0] == $past(cnt_sec))) // R6
        else $error("seconds not captured");
    AST_SNAP_DAY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (regs_q[4][0] == $past(cnt_day[8]) && regs_q[4][7:4] == $past(regs_q[4][7:4]))) // R6
        else $error("fifth register capture wrong");

endmodule

// File: rtl/cbc_addr_map.sv
module cbc_addr_map
    import cbc_pkg::*;
#(
    parameter int unsigned ROM_BANKS = 128,
    parameter int unsigned RAM_BANKS = 4,
    localparam int unsigned ROM_BW   = $clog2(ROM_BANKS),
    localparam int unsigned RAM_BW   = $clog2(RAM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          cpu_addr,
    input  logic                 cpu_wr,
    input  cbc_ctrl_t            ctrl,
    input  logic [7:0]           clk_rdata,
    input  logic [7:0]           ram_rdata,
    output logic [ROM_BW+13:0]   rom_addr,
    output logic [RAM_BW+12:0]   ram_addr,
    output logic                 ram_cs,
    output logic                 ram_we,
    output logic                 clk_we,
    output logic [7:0]           win_rdata
);

    logic              in_window;
    logic [ROM_BW-1:0] bank_eff;

    always_comb begin
        in_window = (cpu_addr[15:13] == 3'b101);
        bank_eff  = ctrl.rom_bank[ROM_BW-1:0];
        rom_addr  = {(cpu_addr[14] ? bank_eff : {ROM_BW{1'b0}}), cpu_addr[13:0]};
        ram_addr  = {ctrl.ram_bank[RAM_BW-1:0], cpu_addr[12:0]};
        ram_cs    = in_window && ctrl.ram_on && !ctrl.clk_sel;
        ram_we    = ram_cs && cpu_wr;
        clk_we    = in_window && cpu_wr && ctrl.clk_sel;
        if (!in_window) begin
            win_rdata = 8'hFF;
        end else if (ctrl.clk_sel) begin
            win_rdata = clk_rdata;
        end else if (ctrl.ram_on) begin
            win_rdata = ram_rdata;
        end else begin
            win_rdata = 8'hFF;
        end
    end

    AST_NO_WE_ON_CONTROL: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_addr[15]) |-> !ram_we) // R1
        else $error("RAM write during control write");
    AST_WINDOW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs |-> (!ctrl.clk_sel && !clk_we)) // R7
        else $error("RAM and clock both own the window");
    AST_BANK0_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00) |-> (rom_addr[ROM_BW+13:14] == '0)) // R8
        else $error("lower ROM half left bank 0");

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int unsigned ROM_BANKS = 128,
    parameter int unsigned RAM_BANKS = 4,
    localparam int unsigned ROM_AW   = $clog2(ROM_BANKS) + 14,
    localparam int unsigned RAM_AW   = $clog2(RAM_BANKS) + 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic [7:0]        ram_rdata,
    input  logic [7:0]        cnt_sec,
    input  logic [7:0]        cnt_min,
    input  logic [7:0]        cnt_hour,
    input  logic [8:0]        cnt_day,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [7:0]        win_rdata
);

    cbc_ctrl_t  ctrl;
    logic       snap_pulse;
    logic       clk_we;
    logic [7:0] clk_rdata;

    cbc_ctrl_regs u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_wr     (cpu_wr),
        .ctrl       (ctrl),
        .snap_pulse (snap_pulse)
    );

    cbc_clock_file u_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap      (snap_pulse),
        .cpu_we    (clk_we),
        .idx       (ctrl.clk_idx),
        .cpu_wdata (cpu_wdata),
        .cnt_sec   (cnt_sec),
        .cnt_min   (cnt_min),
        .cnt_hour  (cnt_hour),
        .cnt_day   (cnt_day),
        .rdata     (clk_rdata)
    );

    cbc_addr_map #(
        .ROM_BANKS (ROM_BANKS),
        .RAM_BANKS (RAM_BANKS)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .ctrl      (ctrl),
        .clk_rdata (clk_rdata),
        .ram_rdata (ram_rdata),
        .rom_addr  (rom_addr),
        .ram_addr  (ram_addr),
        .ram_cs    (ram_cs),
        .ram_we    (ram_we),
        .clk_we    (clk_we),
        .win_rdata (win_rdata)
    );

endmodule

// File: tb/test_cart_bank_ctrl.sv
`timescale 1ns/1ps
module test_cart_bank_ctrl;

    localparam int ROM_BANKS = 32;
    localparam int RAM_BANKS = 4;
    localparam int ROM_AW    = $clog2(ROM_BANKS) + 14;
    localparam int RAM_AW    = $clog2(RAM_BANKS) + 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = 16'h0000;
    logic [7:0]        cpu_wdata = 8'h00;
    logic              cpu_wr = 1'b0;
    logic [7:0]        ram_rdata = 8'h5A;
    logic [7:0]        cnt_sec = 8'h00;
    logic [7:0]        cnt_min = 8'h00;
    logic [7:0]        cnt_hour = 8'h00;
    logic [8:0]        cnt_day = 9'h000;
    logic [ROM_AW-1:0] rom_addr;
    logic [RAM_AW-1:0] ram_addr;
    logic              ram_cs;
    logic              ram_we;
    logic [7:0]        win_rdata;

    always #2.5 clk = ~clk;

    cart_bank_ctrl #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) i_cart_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .ram_rdata(ram_rdata), .cnt_sec(cnt_sec), .cnt_min(cnt_min),
        .cnt_hour(cnt_hour), .cnt_day(cnt_day), .rom_addr(rom_addr), .ram_addr(ram_addr),
        .ram_cs(ram_cs), .ram_we(ram_we), .win_rdata(win_rdata)
    );

    typedef struct {
        int    kind;
        int    exp;
        string tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     ev_sample;
    int       n_total = 0;
    int       n_fail  = 0;
    bit       done    = 0;

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(ev_sample);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                int act;
                it = sb_q.pop_front();
                case (it.kind)
                    0: act = int'(win_rdata);
                    1: act = int'(rom_addr);
                    2: act = int'(ram_addr);
                    3: act = int'(ram_cs);
                    default: act = int'(ram_we);
                endcase
                n_total++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic push_exp(input int kind, input int exp, input string tag);
        sb_item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        @(negedge clk);
        cpu_wr    = 1'b0;
    endtask

    task automatic expect_at(input int kind, input logic [15:0] a, input int exp, input string tag);
        @(negedge clk);
        cpu_addr = a;
        #1;
        push_exp(kind, exp, tag);
        -> ev_sample;
        #1;
    endtask

    task automatic probe_write(input logic [15:0] a, input logic [7:0] d, input int exp_we, input string tag);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        #1;
        push_exp(4, exp_we, tag);
        -> ev_sample;
        #1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        expect_at(0, 16'hA000, 'hFF, "R9 window reads FF");
        expect_at(1, 16'h4123, 'h4123, "R9 bank 1 after reset");
        expect_at(3, 16'hA000, 0, "R9 RAM deselected");
        expect_at(2, 16'hA123, 'h0123, "R9 RAM bank 0");

        // R8 lower half fixed
        expect_at(1, 16'h1234, 'h1234, "R8 bank 0 region");

        // R2 gate
        cpu_write(16'h0000, 8'h0A);
        expect_at(0, 16'hA005, 'h5A, "R2 gate open");
        expect_at(3, 16'hA005, 1, "R2 ram_cs");
        cpu_write(16'h1FFF, 8'h05);
        expect_at(0, 16'hA005, 'h5A, "R2 other value ignored");
        cpu_write(16'h0000, 8'h00);
        expect_at(0, 16'hA005, 'hFF, "R2 gate closed");
        expect_at(3, 16'hA005, 0, "R2 ram_cs off");

        // R12 RAM bank address
        cpu_write(16'h0000, 8'h0A);
        cpu_write(16'h4000, 8'h02);
        expect_at(2, 16'hA010, 'h4010, "R12 bank 2 address");
        expect_at(2, 16'hBFFF, 'h5FFF, "R12 top of window");

        // R11 / R1 write enables
        probe_write(16'hA001, 8'h77, 1, "R11 RAM write enabled");
        probe_write(16'h6100, 8'h55, 0, "R1 control write no ram_we");
        probe_write(16'h0000, 8'h0A, 0, "R1 gate write no ram_we");

        // R3 ROM bank
        cpu_write(16'h2000, 8'h05);
        expect_at(1, 16'h4000, 'h14000, "R3 bank 5");
        cpu_write(16'h3FFF, 8'h00);
        expect_at(1, 16'h7FFF, 'h7FFF, "R3 zero becomes 1");
        cpu_write(16'h2000, 8'h85);
        expect_at(1, 16'h4000, 'h14000, "R3 seven-bit field");

        // R10 wrap
        cpu_write(16'h2000, 8'h25);
        expect_at(1, 16'h4000, 'h14000, "R10 wrap 0x25");
        cpu_write(16'h2000, 8'h3F);
        expect_at(1, 16'h4001, 'h7C001, "R10 wrap 0x3F");

        // R4 select
        cpu_write(16'h4000, 8'h08);
        expect_at(0, 16'hA000, 'h00, "R4 clock reg selected");
        expect_at(3, 16'hA000, 0, "R4 RAM deselected");
        cpu_write(16'h4000, 8'h06);
        expect_at(3, 16'hA000, 0, "R4 value 6 ignored");
        cpu_write(16'h5000, 8'h03);
        expect_at(2, 16'hA000, 'h6000, "R4 RAM bank 3");
        expect_at(0, 16'hA000, 'h5A, "R4 RAM back in window");

        // R5 / R6 capture
        cnt_sec = 8'h12; cnt_min = 8'h34; cnt_hour = 8'h05; cnt_day = 9'h1A7;
        cpu_write(16'h6000, 8'h01);
        cpu_write(16'h4000, 8'h08);
        expect_at(0, 16'hA000, 'h12, "R6 seconds");
        cpu_write(16'h4000, 8'h09);
        expect_at(0, 16'hA000, 'h34, "R6 minutes");
        cpu_write(16'h4000, 8'h0A);
        expect_at(0, 16'hA000, 'h05, "R6 hours");
        cpu_write(16'h4000, 8'h0B);
        expect_at(0, 16'hA000, 'hA7, "R6 day low");
        cpu_write(16'h4000, 8'h0C);
        expect_at(0, 16'hA000, 'h01, "R6 day bit 8");
        cnt_sec = 8'h20;
        cpu_write(16'h4000, 8'h08);
        cpu_write(16'h6000, 8'h01);
        expect_at(0, 16'hA000, 'h12, "R5 repeated 1 no capture");
        cpu_write(16'h6000, 8'h00);
        cpu_write(16'h6000, 8'h01);
        expect_at(0, 16'hA000, 'h20, "R5 0 then 1 captures");

        // R11 clock write, then R6 upper nibble kept
        cpu_write(16'h4000, 8'h0C);
        probe_write(16'hA000, 8'hF3, 0, "R11 clock write no ram_we");
        expect_at(0, 16'hA000, 'hF3, "R11 clock register written");
        cpu_write(16'h6000, 8'h00);
        cpu_write(16'h6000, 8'h01);
        expect_at(0, 16'hA000, 'hF1, "R6 upper nibble kept");

        // R7 priority
        cpu_write(16'h0000, 8'h00);
        expect_at(0, 16'hA000, 'hF1, "R7 clock with RAM off");
        cpu_write(16'h4000, 8'h01);
        expect_at(0, 16'hA000, 'hFF, "R7 neither source");
        expect_at(0, 16'hC000, 'hFF, "R7 outside window");

        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule